// File: doc/BRIEF.md
# Dual-Oscillator Temperature Counting Converter

This block turns the ratio of two oscillator frequencies into a 9-bit signed temperature code. One oscillator has a small temperature coefficient and serves as the reference. The other has a large temperature coefficient and sets the length of the measurement window. Both arrive as free-running pulse trains that are not tied to the system clock. The block brings each into the clock domain and counts its rising edges.

A conversion begins when a start request arrives while the block is idle. That request loads three values. The reference down-counter is loaded with its reload value, the window counter with its length, and the temperature register with the code for -55 °C. During the window, the reference counter decrements on each reference edge. When it reaches its terminal count it reloads, and the temperature register steps up by one half-degree. Each measurement edge shortens the window by one. When the window counter reaches zero, the conversion ends. A one-cycle done strobe then marks the result, and that result stays on the output until the next conversion begins.

Top module: `temp_osc_converter`

## Requirements
- R1: After reset, tempOut holds the -55 °C code 9'h192 and doneOut is low. The code is two's complement with the least significant bit worth 0.5 °C.
- R2: A start request accepted while idle loads the temperature register with 9'h192. It also reloads the reference counter and the window counter, so nothing left over from an earlier conversion affects the new result.
- R3: During a conversion, every REF_RELOAD reference edges raise tempOut by exactly one. With the default REF_RELOAD of 4, N reference edges give 9'h192 + floor(N/4).
- R4: The conversion ends on the MEAS_PRESET-th measurement edge after the start. doneOut is then high for exactly one clock cycle.
- R5: The temperature register saturates at the +125 °C code 9'h0FA and never wraps past it.
- R6: A start request that arrives during a conversion is ignored. Counting continues without any reload.
- R7: Outside a conversion, reference and measurement pulses have no effect. After done, tempOut stays unchanged and doneOut stays low until the next start.
- R8: Each oscillator input is synchronised to the clock. One high pulse counts as one edge, whatever its length, as long as it stays high and low for at least two clock cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Conversion start request |
| refOscIn | input | 1 | Low-coefficient reference oscillator pulses (asynchronous) |
| measOscIn | input | 1 | High-coefficient measurement oscillator pulses (asynchronous) |
| tempOut | output | 9 | Signed temperature code, 0.5 °C per LSB |
| doneOut | output | 1 | One-cycle strobe marking the end of a conversion |

## Verification
The bench runs the following patterns:
- A conversion with no reference pulses, which pins the base code.
- A conversion with ten reference pulses, one of them held high for a long time. A residue-sized follow-up run then shows whether a leftover counter value leaks into the next conversion.
- Reference and measurement pulses interleaved three to one, which checks that both kinds of counting work at the same time.
- A conversion with a start request in the middle. The expected result differs from the one a restarted conversion would produce.
- Pulses while idle, which must change nothing.
- A very long reference burst, which separates saturation from wrap-around.

// File: rtl/tempconv_pkg.sv
package tempconv_pkg;

  localparam int TEMP_W = 9;
  localparam logic signed [TEMP_W-1:0] TEMP_BASE = -9'sd110;  // -55.0 C
  localparam logic signed [TEMP_W-1:0] TEMP_MAX  =  9'sd250;  // +125.0 C

  typedef struct packed {
    logic load;      // preset counters and temperature register
    logic refTick;   // one reference edge to count
    logic measTick;  // one measurement edge to count
  } dpCtl_t;

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscIn,
  output logic riseOut
);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], oscIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign riseOut = syncQ[STAGES-1] & ~prevQ;

  // R8: a detected edge is never followed directly by another one
  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    riseOut |=> !riseOut); // R8

endmodule

// File: rtl/tempconv_ctrl.sv
module tempconv_ctrl
  import tempconv_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startIn,
  input  logic   refEdge,
  input  logic   measEdge,
  input  logic   measLast,
  output dpCtl_t ctl,
  output logic   doneOut
);

  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t stateQ;
  logic   finishing;

  assign finishing = (stateQ == ST_BUSY) && measEdge && measLast;

  always_comb begin
    ctl = '0;
    if (stateQ == ST_IDLE) begin
      ctl.load = startIn;
    end else begin
      ctl.refTick  = refEdge;
      ctl.measTick = measEdge;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      doneOut <= 1'b0;
    end else begin
      doneOut <= finishing;
      case (stateQ)
        ST_IDLE: if (startIn) stateQ <= ST_BUSY;
        ST_BUSY: if (finishing) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R4

  AST_DONE_ONLY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> $past(stateQ) == ST_BUSY); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BUSY && startIn && !finishing) |=> stateQ == ST_BUSY); // R6

endmodule

// File: rtl/tempconv_dp.sv
module tempconv_dp
  import tempconv_pkg::*;
#(
  parameter int REF_RELOAD  = 4,
  parameter int MEAS_PRESET = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  output logic                     measLast,
  output logic signed [TEMP_W-1:0] tempOut
);

  localparam int C1W = $clog2(REF_RELOAD + 1);
  localparam int C2W = $clog2(MEAS_PRESET + 1);
  localparam logic [C1W-1:0] C1_LOAD = C1W'(REF_RELOAD);
  localparam logic [C2W-1:0] C2_LOAD = C2W'(MEAS_PRESET);
  localparam logic [C1W-1:0] C1_ONE  = C1W'(1);
  localparam logic [C2W-1:0] C2_ONE  = C2W'(1);

  logic [C1W-1:0]            refCntQ;
  logic [C2W-1:0]            winCntQ;
  logic signed [TEMP_W-1:0]  tempQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCntQ <= C1_LOAD;
      winCntQ <= C2_LOAD;
      tempQ   <= TEMP_BASE;
    end else if (ctl.load) begin
      refCntQ <= C1_LOAD;
      winCntQ <= C2_LOAD;
      tempQ   <= TEMP_BASE;
    end else begin
      if (ctl.refTick) begin
        if (refCntQ == C1_ONE) begin
          refCntQ <= C1_LOAD;
          if (tempQ != TEMP_MAX) tempQ <= tempQ + 9'sd1;
        end else begin
          refCntQ <= refCntQ - C1_ONE;
        end
      end
      if (ctl.measTick) winCntQ <= winCntQ - C2_ONE;
    end
  end

  assign measLast = (winCntQ == C2_ONE);
  assign tempOut  = tempQ;

  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> tempQ == TEMP_BASE); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && tempQ == TEMP_MAX) |=> tempQ == TEMP_MAX); // R5

  AST_STABLE_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.refTick) |=> $stable(tempQ)); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && ctl.refTick && refCntQ == C1_ONE && tempQ != TEMP_MAX)
      |=> tempQ == $past(tempQ) + 9'sd1); // R3

endmodule

// File: rtl/temp_osc_converter.sv
module temp_osc_converter
  import tempconv_pkg::*;
#(
  parameter int REF_RELOAD  = 4,
  parameter int MEAS_PRESET = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       refOscIn,
  input  logic       measOscIn,
  output logic [8:0] tempOut,
  output logic       doneOut
);

  localparam int NUM_OSC = 2;

  logic [NUM_OSC-1:0] oscRaw;
  logic [NUM_OSC-1:0] oscRise;
  dpCtl_t             ctl;
  logic               measLast;
  logic signed [TEMP_W-1:0] tempVal;

  assign oscRaw = {measOscIn, refOscIn};

  for (genvar g = 0; g < NUM_OSC; g++) begin : gSync
    osc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rstN   (rstN),
      .oscIn  (oscRaw[g]),
      .riseOut(oscRise[g])
    );
  end

  tempconv_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .refEdge (oscRise[0]),
    .measEdge(oscRise[1]),
    .measLast(measLast),
    .ctl     (ctl),
    .doneOut (doneOut)
  );

  tempconv_dp #(.REF_RELOAD(REF_RELOAD), .MEAS_PRESET(MEAS_PRESET)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .measLast(measLast),
    .tempOut (tempVal)
  );

  assign tempOut = tempVal;

endmodule

// File: tb/test_temp_osc_converter.sv
module test_temp_osc_converter;

  localparam int RELOAD = 4;
  localparam int WINDOW = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic       refOscIn = 1'b0;
  logic       measOscIn = 1'b0;
  logic [8:0] tempOut;
  logic       doneOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  logic [8:0] expQ[$];
  logic prevDone = 1'b0;

  always #2.5 clk = ~clk;

  temp_osc_converter #(.REF_RELOAD(RELOAD), .MEAS_PRESET(WINDOW)) i_temp_osc_converter (
    .clk(clk), .rstN(rstN), .startIn(startIn), .refOscIn(refOscIn),
    .measOscIn(measOscIn), .tempOut(tempOut), .doneOut(doneOut)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_code(input int refEdges);
    int v;
    v = -110 + refEdges / RELOAD;
    if (v > 250) v = 250;
    return 9'(v);
  endfunction

  // monitor: pops an expected result on every done strobe
  always @(negedge clk) begin
    cycles++;
    if (doneOut) begin
      if (prevDone) check("R4 done width", 9'd1, 9'd0);
      if (expQ.size() == 0) check("R7 unexpected done", 9'd1, 9'd0);
      else check("R3/R4 result", tempOut, expQ.pop_front());
    end
    prevDone = doneOut;
  end

  task automatic refPulse(input int hi);
    @(negedge clk) refOscIn = 1'b1;
    repeat (hi) @(negedge clk);
    refOscIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic measPulse();
    @(negedge clk) measOscIn = 1'b1;
    repeat (2) @(negedge clk);
    measOscIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic startConv(input logic [8:0] exp);
    expQ.push_back(exp);
    @(negedge clk) startIn = 1'b1;
    @(negedge clk) startIn = 1'b0;
  endtask

  task automatic finishWindow();
    for (int i = 0; i < WINDOW; i++) measPulse();
    repeat (6) @(negedge clk);
    check("R4 all results delivered", 9'(expQ.size()), 9'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset temp", tempOut, 9'h192);
    check("R1 reset done", {8'd0, doneOut}, 9'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // no reference edges: base code
    startConv(9'h192);
    check("R2 base after start", tempOut, 9'h192);
    finishWindow();

    // ten reference edges, one held long: R8 counts it once
    startConv(expect_code(10));
    for (int i = 0; i < 10; i++) refPulse(i == 4 ? 20 : 2);
    check("R3 mid-conversion value", tempOut, expect_code(10));
    finishWindow();

    // residue of 2 must not leak: three edges give no step
    startConv(expect_code(3));
    for (int i = 0; i < 3; i++) refPulse(2);
    finishWindow();

    // interleaved three reference edges per window edge
    startConv(expect_code(3 * WINDOW));
    for (int i = 0; i < WINDOW; i++) begin
      for (int j = 0; j < 3; j++) refPulse(2);
      measPulse();
    end
    repeat (6) @(negedge clk);
    check("R3 interleaved delivered", 9'(expQ.size()), 9'd0);

    // start during conversion ignored
    startConv(expect_code(8));
    for (int i = 0; i < 5; i++) refPulse(2);
    @(negedge clk) startIn = 1'b1;
    @(negedge clk) startIn = 1'b0;
    check("R6 no reload on busy start", tempOut, expect_code(5));
    for (int i = 0; i < 3; i++) refPulse(2);
    finishWindow();

    // idle pulses change nothing
    for (int i = 0; i < 8; i++) refPulse(2);
    for (int i = 0; i < 8; i++) measPulse();
    check("R7 idle stable", tempOut, expect_code(8));

    // saturation
    startConv(9'h0FA);
    for (int i = 0; i < 1500; i++) refPulse(2);
    check("R5 saturated", tempOut, 9'h0FA);
    finishWindow();
    check("R5 held after done", tempOut, 9'h0FA);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule